// File: doc/BRIEF.md
# Supply Detection Sampling Controller

This block sequences the sampling of two supply-voltage comparators: a main detector with a programmable threshold and a sub detector with a fixed threshold. A sample raises the comparator enable for a fixed settle time. On the last settle cycle it writes both comparator outputs into result flops. A sample starts on a software one-shot strobe. It also starts on a slow prescaler tick whenever periodic sampling is active.

Periodic sampling is active while software holds the heavy-load bit. It is also active while a hardware trip is held. The trip is raised by a sample in which the sub detector reports low supply. It is cleared only by a later sample in which the main detector reports the supply back at or above its threshold. A build parameter decides whether a held trip also drives the heavy-load status output. The analog comparators, the references and the regulator switching are outside this block and appear only as digital pins.

Top module: `supply_detect_sequencer`

## Requirements
- R1: After reset, both result outputs are 0 (0 means supply OK), the comparator enable and latch strobe are 0, no trip is held, and the heavy-load status equals the software bit.
- R2: A software strobe seen while idle starts a sample. The enable goes high from the next clock edge and stays high for exactly SETTLE clock cycles.
- R3: The latch strobe is high only in the last enable cycle. At the end of that cycle, main_low_q and sub_low_q take the comparator inputs (1 = supply low). At all other times they hold their values.
- R4: A strobe or tick that arrives while a sample runs is ignored. A strobe and a tick in the same idle cycle start one sample only.
- R5: With the software heavy-load bit at 1, every tick seen while idle starts a sample.
- R6: With the software bit at 0 and no trip held, ticks start no sample.
- R7: A sample whose sub result is 1 sets the hardware trip. From then on, ticks start samples even with the software bit at 0.
- R8: A held trip clears only at a sample whose main result is 0 and whose sub result is 0. If the same sample has sub result 1, setting wins.
- R9: heavy_mode is sw_heavy OR (trip AND SUB_FORCES_HEAVY). With SUB_FORCES_HEAVY = 0, it follows sw_heavy alone.
- R10: heavy_mode follows the software bit in the same cycle. Clearing the bit while no trip is held stops tick acceptance at once. A sample already running still completes its full SETTLE cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_heavy | input | 1 | Software heavy-load mode bit |
| sw_detect | input | 1 | Software one-shot detect strobe |
| tick_2hz | input | 1 | Prescaler tick, one cycle wide |
| main_cmp_low | input | 1 | Main comparator output, 1 = supply low |
| sub_cmp_low | input | 1 | Sub comparator output, 1 = supply low |
| cmp_enable | output | 1 | Comparator enable during a sample |
| latch_strobe | output | 1 | High in the cycle whose end writes the results |
| main_low_q | output | 1 | Latched main result |
| sub_low_q | output | 1 | Latched sub result |
| heavy_mode | output | 1 | Effective heavy-load mode status |

## Verification
Two collisions can land on the same cycle. One is a software strobe together with a prescaler tick. The other is a trip-setting sub result together with a recovering main result. The bench raises strobe and tick on the same idle cycle and requires exactly one SETTLE-long enable window, followed by a low cycle. It also drives sub low with main OK into a single sample and requires the trip to be held afterwards. The sweep covers every combination of both comparator inputs and the software bit. The expected trip state is tracked arithmetically in the bench, and each case is judged at the ports through heavy_mode and through whether the next tick starts a sample.

// File: rtl/supply_detect_sequencer.sv
module supply_detect_sequencer #(
  parameter int SETTLE = 4,
  parameter bit SUB_FORCES_HEAVY = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_heavy,
  input  logic sw_detect,
  input  logic tick_2hz,
  input  logic main_cmp_low,
  input  logic sub_cmp_low,
  output logic cmp_enable,
  output logic latch_strobe,
  output logic main_low_q,
  output logic sub_low_q,
  output logic heavy_mode
);
  localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic          hw_trip;
  logic          periodic;
  logic          start;

  assign periodic     = sw_heavy | hw_trip;
  assign start        = !busy && (sw_detect || (tick_2hz && periodic));
  assign cmp_enable   = busy;
  assign latch_strobe = busy && (cnt == LAST);
  assign heavy_mode   = sw_heavy | (SUB_FORCES_HEAVY & hw_trip);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (latch_strobe) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_low_q <= 1'b0;
      sub_low_q  <= 1'b0;
      hw_trip    <= 1'b0;
    end else if (latch_strobe) begin
      main_low_q <= main_cmp_low;
      sub_low_q  <= sub_cmp_low;
      if (sub_cmp_low)       hw_trip <= 1'b1;
      else if (!main_cmp_low) hw_trip <= 1'b0;
    end
  end

  assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_enable) |-> $past(sw_detect || (tick_2hz && periodic)));
  assert_hold_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_enable && !latch_strobe) |=> cmp_enable);
  assert_drop_after_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    latch_strobe |=> !cmp_enable);
  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    latch_strobe |=> (main_low_q == $past(main_cmp_low)) && (sub_low_q == $past(sub_cmp_low)));
  assert_results_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_strobe |=> $stable(main_low_q) && $stable(sub_low_q));
  assert_trip_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hw_trip) |-> $past(latch_strobe && sub_cmp_low));
  assert_trip_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hw_trip) |-> $past(latch_strobe && !main_cmp_low && !sub_cmp_low));
endmodule

// File: tb/supply_detect_sequencer_tb.sv
module supply_detect_sequencer_tb_top;
  localparam int SETTLE = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_heavy = 1'b0, sw_detect = 1'b0, tick_2hz = 1'b0;
  logic main_cmp_low = 1'b0, sub_cmp_low = 1'b0;
  logic cmp_enable, latch_strobe, main_low_q, sub_low_q, heavy_mode;
  logic nv_en, nv_ls, nv_m, nv_s, nv_heavy;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit model_trip = 1'b0;

  always #2.5 clk = ~clk;

  supply_detect_sequencer #(.SETTLE(SETTLE), .SUB_FORCES_HEAVY(1'b1)) dut_i (
    .clk, .rst_n, .sw_heavy, .sw_detect, .tick_2hz, .main_cmp_low, .sub_cmp_low,
    .cmp_enable, .latch_strobe, .main_low_q, .sub_low_q, .heavy_mode);

  supply_detect_sequencer #(.SETTLE(SETTLE), .SUB_FORCES_HEAVY(1'b0)) dut_nv (
    .clk, .rst_n, .sw_heavy, .sw_detect, .tick_2hz, .main_cmp_low, .sub_cmp_low,
    .cmp_enable(nv_en), .latch_strobe(nv_ls), .main_low_q(nv_m), .sub_low_q(nv_s),
    .heavy_mode(nv_heavy));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input bit strobe, input bit tick);
    sw_detect = strobe;
    tick_2hz  = tick;
    @(negedge clk);
    sw_detect = 1'b0;
    tick_2hz  = 1'b0;
  endtask

  task automatic window(input logic em, input logic es);
    for (int k = 1; k <= SETTLE; k++) begin
      chk("R2 enable in window", cmp_enable, 1);
      chk("R3 strobe position", latch_strobe, (k == SETTLE));
      @(negedge clk);
    end
    chk("R2 enable after window", cmp_enable, 0);
    chk("R3 main result", main_low_q, em);
    chk("R3 sub result", sub_low_q, es);
    if (es) model_trip = 1'b1;
    else if (!em) model_trip = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset enable", cmp_enable, 0);
    chk("R1 reset main", main_low_q, 0);
    chk("R1 reset sub", sub_low_q, 0);
    chk("R1 reset heavy", heavy_mode, 0);
    rst_n = 1'b1;
    @(negedge clk);
    pulse(0, 1);
    chk("R6 tick ignored idle", cmp_enable, 0);

    for (int sw = 0; sw < 2; sw++)
      for (int m = 0; m < 2; m++)
        for (int s = 0; s < 2; s++) begin
          sw_heavy = sw[0];
          main_cmp_low = m[0];
          sub_cmp_low = s[0];
          pulse(1, 0);
          window(m[0], s[0]);
          #1;
          chk("R9 heavy variant", heavy_mode, sw[0] | model_trip);
          chk("R9 heavy no variant", nv_heavy, sw[0]);
          pulse(0, 1);
          chk("R5 R6 R7 tick sampling", cmp_enable, sw[0] | model_trip);
          repeat (SETTLE + 1) @(negedge clk);
        end

    sw_heavy = 1'b0; main_cmp_low = 1'b1; sub_cmp_low = 1'b1;
    pulse(1, 0);
    window(1, 1);
    chk("R7 trip held", heavy_mode, 1);
    main_cmp_low = 1'b0; sub_cmp_low = 1'b0;
    pulse(0, 1);
    window(0, 0);
    #1;
    chk("R8 trip cleared", heavy_mode, 0);
    pulse(0, 1);
    chk("R8 periodic stopped", cmp_enable, 0);

    pulse(1, 1);
    window(0, 0);
    chk("R4 single sample on collision", cmp_enable, 0);
    pulse(1, 0);
    chk("R4 sample started", cmp_enable, 1);
    pulse(1, 0);
    repeat (SETTLE - 2) @(negedge clk);
    chk("R4 last cycle", latch_strobe, 1);
    @(negedge clk);
    chk("R4 strobe while busy ignored", cmp_enable, 0);

    sw_heavy = 1'b1;
    #1;
    chk("R10 heavy follows bit", heavy_mode, 1);
    pulse(0, 1);
    sw_heavy = 1'b0;
    #1;
    chk("R10 heavy drops same cycle", heavy_mode, 0);
    window(0, 0);
    pulse(0, 1);
    chk("R10 ticks no longer accepted", cmp_enable, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule